// File: doc/BRIEF.md
# Planar Graphics Raster Write Unit

This block sits between a CPU data window and three 1-bit-per-pixel graphics planes held inside it: plane 0 carries blue, plane 1 red and plane 2 green, each plane a byte-wide store of eight linear pixels per address. Two control registers decide what a CPU access does. With the window set to main RAM, accesses pass straight through to an external main-RAM port. With the window set to graphics memory, one CPU byte write updates all three planes at once, either as a per-plane raster operation under a pixel mask, as a copy of previously latched plane bytes, or as a transfer of one plane's latched byte into another plane.

A graphics-window read does not return raw plane bits. It captures the three plane bytes at the address into an internal latch and returns, for each pixel, whether that pixel's colour equals a compare colour held in the mode register. The latch is the source for the copy and transfer modes, so a read followed by a write moves a whole three-plane byte column with two CPU accesses. Graphics-window accesses take two cycles: the request is accepted, and in the following cycle the result is returned and written back with `cpu_ready` high.

Top module: `plane_raster_alu`

## Requirements
- R1: After reset both control registers read as zero in effect: the window is main RAM, so a CPU access drives `mem_req` and completes in the same cycle with `cpu_ready` high and `cpu_rdata` equal to `mem_rdata`.
- R2: Mode register (selected by `reg_sel`=1) bit 7 picks the CPU window: 0 routes accesses to the main-RAM port, 1 routes them to the planes and keeps `mem_req` low.
- R3: In raster mode (mode bits 5:4 = 00) plane p uses op {ctl[4+p], ctl[p]} from the op register (`reg_sel`=0): 00 clears, 01 sets, 10 inverts, 11 leaves the pixel as it was.
- R4: In raster mode a pixel whose bit in the written CPU byte is 0 keeps its old value on every plane.
- R5: A graphics-window read in mode 00 or 01 returns, per pixel, 1 exactly when plane p equals mode bit p for all three planes, and loads the three plane bytes into the latch.
- R6: In copy mode (bits 5:4 = 01) a write stores latch byte p into plane p for every plane; the CPU write data has no effect.
- R7: In mode 10 a write stores the latched red byte into the blue plane at the address; red and green are unchanged.
- R8: In mode 11 a write stores the latched blue byte into the red plane at the address; blue and green are unchanged.
- R9: A graphics-window access is accepted when `cpu_req` is high and no access is in flight; `cpu_ready` is high for exactly the next cycle, and a request held during that cycle is not accepted again.
- R10: A graphics-window read in mode 10 or 11 returns 0x00 and still loads the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control register write strobe |
| reg_sel | input | 1 | 0 selects the op register, 1 the mode register |
| reg_wdata | input | 8 | Control register write data |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | AW | CPU byte address within the window |
| cpu_wdata | input | 8 | CPU write byte (pixel mask in raster mode) |
| cpu_rdata | output | 8 | CPU read byte |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_req | output | 1 | Main-RAM access request |
| mem_we | output | 1 | Main-RAM write enable |
| mem_addr | output | AW | Main-RAM address |
| mem_wdata | output | 8 | Main-RAM write byte |
| mem_rdata | input | 8 | Main-RAM read byte |

## Verification
A wrong latch or plane word shows up only at the next graphics-window read, as a mismatch in the compare result, so the bench reads each touched address back under several compare colours to pull each plane apart; that read is one access after the faulty write. A wrong in-flight flag shows in the same or next cycle as a missing, doubled or early `cpu_ready`, or as `mem_req` firing while the graphics window is selected.

// File: rtl/plane_raster_alu.sv
module plane_raster_alu #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_sel,
  input  logic [7:0]    reg_wdata,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  output logic          cpu_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int NPL = 3;

  logic [7:0]    op_ctl, mode_ctl;
  logic          busy, we_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    wd_q;
  logic [23:0]   latch, plane_rd, plane_nx;

  wire       gwin = mode_ctl[7];
  wire [1:0] dmux = mode_ctl[5:4];
  wire [2:0] cmp  = mode_ctl[2:0];

  genvar p;
  generate
    for (p = 0; p < NPL; p++) begin : g_plane
      logic [7:0] store [DEPTH];
      logic [7:0] cur, nx;
      logic [1:0] op;
      assign cur = store[addr_q];
      assign op  = {op_ctl[4+p], op_ctl[p]};
      assign plane_rd[p*8 +: 8] = cur;
      assign plane_nx[p*8 +: 8] = nx;
      always_comb begin
        nx = cur;
        case (dmux)
          2'b00: case (op)
            2'b00:   nx = cur & ~wd_q;
            2'b01:   nx = cur | wd_q;
            2'b10:   nx = cur ^ wd_q;
            default: nx = cur;
          endcase
          2'b01: nx = latch[p*8 +: 8];
          2'b10: if (p == 0) nx = latch[15:8];
          default: if (p == 1) nx = latch[7:0];
        endcase
      end
      always_ff @(posedge clk)
        if (busy && we_q) store[addr_q] <= nx;
    end
  endgenerate

  wire [7:0] match = ~(plane_rd[7:0]   ^ {8{cmp[0]}})
                   & ~(plane_rd[15:8]  ^ {8{cmp[1]}})
                   & ~(plane_rd[23:16] ^ {8{cmp[2]}});

  assign mem_req   = cpu_req & ~gwin & ~busy;
  assign mem_we    = cpu_we;
  assign mem_addr  = cpu_addr;
  assign mem_wdata = cpu_wdata;
  assign cpu_ready = busy | mem_req;
  assign cpu_rdata = gwin ? (dmux[1] ? 8'h00 : match) : mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_ctl   <= '0;
      mode_ctl <= '0;
      busy     <= 1'b0;
      we_q     <= 1'b0;
      addr_q   <= '0;
      wd_q     <= '0;
      latch    <= '0;
    end else begin
      if (reg_we && !reg_sel) op_ctl   <= reg_wdata;
      if (reg_we &&  reg_sel) mode_ctl <= reg_wdata;
      busy <= !busy && cpu_req && gwin;
      if (!busy && cpu_req && gwin) begin
        we_q   <= cpu_we;
        addr_q <= cpu_addr;
        wd_q   <= cpu_wdata;
      end
      if (busy && !we_q) latch <= plane_rd;
    end
  end
endmodule

// File: rtl/plane_raster_alu_chk.sv
module plane_raster_alu_chk (
  input logic        clk,
  input logic        rst,
  input logic        gwin,
  input logic [1:0]  dmux,
  input logic        busy,
  input logic        we_q,
  input logic [7:0]  wd_q,
  input logic [23:0] latch,
  input logic [23:0] plane_rd,
  input logic        cpu_req,
  input logic        cpu_ready,
  input logic        mem_req
);
  a_r9_single_cycle: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);
  a_r9_accept: assert property (@(posedge clk) disable iff (rst)
    (!busy && cpu_req && gwin) |=> (busy && cpu_ready));
  a_r2_no_main_in_flight: assert property (@(posedge clk) disable iff (rst)
    busy |-> !mem_req);
  a_r5_latch_load: assert property (@(posedge clk) disable iff (rst)
    (busy && !we_q) |=> latch == $past(plane_rd));
  a_r4_mask_keeps: assert property (@(posedge clk) disable iff (rst)
    (busy && we_q && dmux == 2'b00) |=>
      ((plane_rd ^ $past(plane_rd)) & ~{3{$past(wd_q)}}) == 24'h0);
  a_r6_copy_all: assert property (@(posedge clk) disable iff (rst)
    (busy && we_q && dmux == 2'b01) |=> plane_rd == $past(latch));
  a_r7_red_to_blue: assert property (@(posedge clk) disable iff (rst)
    (busy && we_q && dmux == 2'b10) |=>
      (plane_rd[7:0] == $past(latch[15:8]) && plane_rd[23:8] == $past(plane_rd[23:8])));
  a_r8_blue_to_red: assert property (@(posedge clk) disable iff (rst)
    (busy && we_q && dmux == 2'b11) |=>
      (plane_rd[15:8] == $past(latch[7:0]) && plane_rd[7:0] == $past(plane_rd[7:0])
       && plane_rd[23:16] == $past(plane_rd[23:16])));
endmodule

bind plane_raster_alu plane_raster_alu_chk u_chk (
  .clk(clk), .rst(rst), .gwin(gwin), .dmux(dmux), .busy(busy), .we_q(we_q),
  .wd_q(wd_q), .latch(latch), .plane_rd(plane_rd), .cpu_req(cpu_req),
  .cpu_ready(cpu_ready), .mem_req(mem_req)
);

// File: tb/plane_raster_alu_test.sv
module plane_raster_alu_test;
  localparam int AW = 6;
  logic clk = 0, rst = 1;
  logic reg_we = 0, reg_sel = 0, cpu_req = 0, cpu_we = 0;
  logic [7:0] reg_wdata = 0, cpu_wdata = 0;
  logic [AW-1:0] cpu_addr = 0;
  logic [7:0] cpu_rdata, mem_wdata, mem_rdata;
  logic cpu_ready, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  always #5 clk = ~clk;

  plane_raster_alu #(.AW(AW)) uut (.*);

  logic [7:0] bram [64];
  always @(posedge clk) if (mem_req && mem_we) bram[mem_addr] <= mem_wdata;
  assign mem_rdata = bram[mem_addr];

  int errors = 0, checks = 0;
  logic [7:0] op_s = 0, mode_s = 0;
  logic [7:0] pm [3][64];
  logic [7:0] lat [3];
  logic [7:0] ram_m [64];
  logic [7:0] exp_q [$];
  string tag_q [$];
  logic rd_flag = 0;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rd_flag && cpu_ready && exp_q.size() > 0)
      check(tag_q.pop_front(), cpu_rdata, exp_q.pop_front());

  task automatic set_reg(logic sel, logic [7:0] v);
    @(negedge clk); #1;
    reg_we = 1; reg_sel = sel; reg_wdata = v;
    @(negedge clk); #1;
    reg_we = 0;
    if (sel) mode_s = v; else op_s = v;
  endtask

  task automatic access(logic we, logic [AW-1:0] a, logic [7:0] d, string tag);
    logic [7:0] e;
    @(negedge clk); #1;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; rd_flag = !we;
    if (!mode_s[7]) begin
      if (!we) begin exp_q.push_back(ram_m[a]); tag_q.push_back(tag); end
      else ram_m[a] = d;
    end else if (!we) begin
      e = 8'hFF;
      for (int p = 0; p < 3; p++) e &= ~(pm[p][a] ^ {8{mode_s[p]}});
      exp_q.push_back(mode_s[5] ? 8'h00 : e); tag_q.push_back(tag);
      for (int p = 0; p < 3; p++) lat[p] = pm[p][a];
    end else begin
      for (int p = 0; p < 3; p++)
        case (mode_s[5:4])
          2'b00: case ({op_s[4+p], op_s[p]})
            2'b00: pm[p][a] = pm[p][a] & ~d;
            2'b01: pm[p][a] = pm[p][a] | d;
            2'b10: pm[p][a] = pm[p][a] ^ d;
            default: ;
          endcase
          2'b01: pm[p][a] = lat[p];
          2'b10: if (p == 0) pm[0][a] = lat[1];
          default: if (p == 1) pm[1][a] = lat[0];
        endcase
    end
    @(negedge clk);
    check({tag, " ready"}, {7'b0, cpu_ready}, 8'h01);
    #1 cpu_req = 0; rd_flag = 0;
  endtask

  task automatic probe(logic [AW-1:0] a, string tag);
    logic [7:0] keep;
    keep = mode_s;
    for (int c = 0; c < 8; c++) begin
      set_reg(1, 8'h80 | c[7:0]);
      access(0, a, 0, tag);
    end
    set_reg(1, keep);
  endtask

  task automatic paint(logic [AW-1:0] a, logic [7:0] b, logic [7:0] r, logic [7:0] g);
    set_reg(1, 8'h80);
    set_reg(0, 8'h00); access(1, a, 8'hFF, "R3 clear");
    set_reg(0, 8'h67); access(1, a, b, "R3 set blue");
    set_reg(0, 8'h57); access(1, a, r, "R3 set red");
    set_reg(0, 8'h37); access(1, a, g, "R3 set green");
  endtask

  initial begin
    int rdy;
    for (int i = 0; i < 64; i++) begin
      ram_m[i] = 0; bram[i] = 0;
      for (int p = 0; p < 3; p++) pm[p][i] = 0;
    end
    for (int p = 0; p < 3; p++) lat[p] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 ready idle", {7'b0, cpu_ready}, 8'h00);
    check("R1 mem_req idle", {7'b0, mem_req}, 8'h00);
    access(1, 5, 8'hA5, "R1 main write");
    access(0, 5, 0, "R1 main read");

    paint(1, 8'hF0, 8'hCC, 8'hAA);
    probe(1, "R5 compare after paint");
    check("R2 mem_req quiet in gfx", {7'b0, mem_req}, 8'h00);
    set_reg(0, 8'h56);
    access(1, 1, 8'h3C, "R3 mixed ops");
    probe(1, "R3 mixed ops readback");
    set_reg(0, 8'h70);
    access(1, 1, 8'h00, "R4 zero mask");
    probe(1, "R4 zero mask readback");
    set_reg(0, 8'h07);
    access(1, 1, 8'h81, "R4 partial mask");
    probe(1, "R4 partial mask readback");

    paint(2, 8'h12, 8'h34, 8'h56);
    set_reg(1, 8'h87); access(0, 2, 0, "R5 latch load");
    set_reg(1, 8'h90); access(1, 9, 8'h3C, "R6 copy write");
    probe(9, "R6 copy readback");

    paint(4, 8'h0F, 8'hE1, 8'h99);
    set_reg(1, 8'h80); access(0, 4, 0, "R5 latch load");
    set_reg(1, 8'hA0); access(1, 4, 8'hFF, "R7 red to blue");
    probe(4, "R7 readback");
    paint(6, 8'h5A, 8'h0C, 8'h77);
    set_reg(1, 8'hB7); access(0, 6, 0, "R10 transfer read zero");
    access(1, 6, 8'h00, "R8 blue to red");
    probe(6, "R8 readback");

    set_reg(0, 8'h07); set_reg(1, 8'h80);
    @(negedge clk); #1;
    cpu_req = 1; cpu_we = 1; cpu_addr = 12; cpu_wdata = 8'h18;
    for (int p = 0; p < 3; p++) pm[p][12] |= 8'h18;
    rdy = 0;
    @(negedge clk); rdy += cpu_ready;
    @(negedge clk); rdy += cpu_ready; #1 cpu_req = 0;
    @(negedge clk); rdy += cpu_ready;
    check("R9 one ready per held request", rdy[7:0], 8'h01);
    probe(12, "R9 held write readback");

    set_reg(1, 8'h00);
    access(0, 5, 0, "R2 main window again");
    access(1, 7, 8'h3E, "R2 main write");
    access(0, 7, 0, "R2 main read");
    set_reg(1, 8'h87); access(0, 7, 0, "R2 planes untouched");

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule